// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block sits behind a CAN / CAN FD receiver. For each received message it decides whether the message is kept, and which of two receive FIFOs gets it. The receiver presents the identifier with its frame-format bits and a one-cycle valid strobe. The block then tests the message against a bank of mask/code filter pairs. Each pair has its own enable bit.

Every enabled filter is evaluated in parallel. The lowest-numbered filter that matches sets the reported filter number and the routing. A routing partition field splits the bank between the two FIFOs. Its all-ones value switches the second FIFO off, so every accepted message then goes to FIFO-0.

The filter state (masks, codes, enables, partition) comes from the surrounding register file. It is sampled only in the cycle the strobe is high. The decision comes out one clock later as a single-cycle pulse.

Top module: `can_acc_bank`

## Requirements
- R1: The identifier is packed into a 32-bit compare word before matching. For an extended frame, bits 31:21 hold identifier bits 28:18, bits 20 and 19 are both 1, bits 18:1 hold identifier bits 17:0, and bit 0 holds the remote flag. For a standard frame, bits 31:21 hold identifier bits 10:0, bit 20 holds the remote flag, and bits 19:0 are 0.
- R2: Filter k matches when (compare word AND mask k) equals (code k AND mask k). A mask bit of 0 makes that bit a don't-care.
- R3: A filter whose enable bit is 0 never matches. With all enable bits 0, every message is rejected.
- R4: A message is accepted (res_accept = 1) when at least one enabled filter matches, and rejected otherwise.
- R5: When several enabled filters match, res_index reports the lowest-numbered one.
- R6: When the partition field is all ones (31 for 32 filters), every accepted message goes to FIFO-0 (res_fifo_sel = 0).
- R7: When the partition field is below all ones, a match from filter k with k <= partition goes to FIFO-0, and one with k > partition goes to FIFO-1 (res_fifo_sel = 1).
- R8: res_valid is high in exactly the cycle after each cycle in which id_valid is high, and low otherwise. Back-to-back strobes give back-to-back results.
- R9: The decision uses the mask, code, enable and partition values present in the strobe cycle. Changes made in the following cycle do not alter it.
- R10: During reset, res_valid, res_accept, res_fifo_sel and res_index are all 0.
- R11: A rejected message reports res_fifo_sel = 0 and res_index = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | One-cycle strobe: a received identifier is present |
| id_ident | input | 29 | Received identifier; standard frames use bits 10:0 |
| id_ext | input | 1 | 1 = extended-format frame |
| id_rtr | input | 1 | Remote-request flag of the frame |
| flt_mask | input | NUM_FILT x 32 | Per-filter compare mask |
| flt_code | input | NUM_FILT x 32 | Per-filter compare code |
| flt_enable | input | NUM_FILT | Per-filter enable |
| part_sel | input | IDX_W | Routing partition; all ones turns FIFO-1 off |
| res_valid | output | 1 | One-cycle pulse: decision available |
| res_accept | output | 1 | Message accepted |
| res_fifo_sel | output | 1 | 0 = FIFO-0, 1 = FIFO-1 |
| res_index | output | IDX_W | Number of the winning filter |

## Verification
The bench builds the bank with its default of 32 filters. The reserved partition value 31 is then also the index of the last filter. This puts both the FIFO-1 switch-off and the topmost partition boundary in reach with the same 5-bit field.

Overlapping filters are placed at indices 2 and 25, and a match-all filter sits at index 12. With these, the bench exercises the lowest-index rule, the effect of the enable bits and the boundary k equal to the partition value. Frames of both formats hit partial and full masks. This exposes the placement of the remote and format bits in the compare word.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int unsigned CMP_W = 32;
  localparam int unsigned ID_W  = 29;
  localparam int unsigned STD_W = 11;

  // Builds the common compare word for both frame formats.
  function automatic logic [CMP_W-1:0] can_acc_pack(
    input logic [ID_W-1:0] ident,
    input logic            ext,
    input logic            rtr
  );
    logic [CMP_W-1:0] w;
    if (ext) begin
      w = {ident[ID_W-1:ID_W-STD_W], 1'b1, 1'b1, ident[ID_W-STD_W-1:0], rtr};
    end else begin
      w = {ident[STD_W-1:0], rtr, {(CMP_W-STD_W-1){1'b0}}};
    end
    return w;
  endfunction
endpackage

// File: rtl/can_acc_rst_sync.sv
module can_acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/can_acc_format.sv
module can_acc_format
  import can_acc_pkg::*;
(
  input  logic [ID_W-1:0]  ident,
  input  logic             ext,
  input  logic             rtr,
  output logic [CMP_W-1:0] cmp_word
);
  always_comb begin
    cmp_word = can_acc_pack(ident, ext, rtr);
  end
endmodule

// File: rtl/can_acc_match.sv
module can_acc_match
  import can_acc_pkg::*;
#(
  parameter int unsigned NUM_FILT = 32
) (
  input  logic [CMP_W-1:0]                cmp_word,
  input  logic [NUM_FILT-1:0][CMP_W-1:0]  flt_mask,
  input  logic [NUM_FILT-1:0][CMP_W-1:0]  flt_code,
  input  logic [NUM_FILT-1:0]             flt_enable,
  output logic [NUM_FILT-1:0]             hit_vec
);
  for (genvar k = 0; k < NUM_FILT; k++) begin : g_flt
    logic [CMP_W-1:0] diff;
    always_comb begin
      diff       = (cmp_word ^ flt_code[k]) & flt_mask[k];
      hit_vec[k] = flt_enable[k] && (diff == '0);
    end
  end
endmodule

// File: rtl/can_acc_pick.sv
module can_acc_pick #(
  parameter int unsigned NUM_FILT = 32,
  parameter int unsigned IDX_W    = $clog2(NUM_FILT)
) (
  input  logic [NUM_FILT-1:0] hit_vec,
  input  logic [IDX_W-1:0]    part_sel,
  output logic                accept,
  output logic                fifo_sel,
  output logic [IDX_W-1:0]    index
);
  localparam logic [IDX_W-1:0] PART_OFF = '1;

  logic             found;
  logic [IDX_W-1:0] win;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        win   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    accept   = found;
    index    = win;
    fifo_sel = found && (part_sel != PART_OFF) && (win > part_sel);
  end
endmodule

// File: rtl/can_acc_bank.sv
module can_acc_bank
  import can_acc_pkg::*;
#(
  parameter int unsigned NUM_FILT = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_FILT)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            id_valid,
  input  logic [28:0]                     id_ident,
  input  logic                            id_ext,
  input  logic                            id_rtr,
  input  logic [NUM_FILT-1:0][31:0]       flt_mask,
  input  logic [NUM_FILT-1:0][31:0]       flt_code,
  input  logic [NUM_FILT-1:0]             flt_enable,
  input  logic [IDX_W-1:0]                part_sel,
  output logic                            res_valid,
  output logic                            res_accept,
  output logic                            res_fifo_sel,
  output logic [IDX_W-1:0]                res_index
);
  logic             rst_q_n;
  logic [CMP_W-1:0] cmp_word;
  logic [NUM_FILT-1:0] hit_vec;
  logic             pick_acc;
  logic             pick_fifo;
  logic [IDX_W-1:0] pick_idx;

  logic             valid_d, valid_q;
  logic             acc_d, acc_q;
  logic             fifo_d, fifo_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             cap_en;

  can_acc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  can_acc_format u_fmt (
    .ident    (id_ident),
    .ext      (id_ext),
    .rtr      (id_rtr),
    .cmp_word (cmp_word)
  );

  can_acc_match #(.NUM_FILT(NUM_FILT)) u_match (
    .cmp_word   (cmp_word),
    .flt_mask   (flt_mask),
    .flt_code   (flt_code),
    .flt_enable (flt_enable),
    .hit_vec    (hit_vec)
  );

  can_acc_pick #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_pick (
    .hit_vec  (hit_vec),
    .part_sel (part_sel),
    .accept   (pick_acc),
    .fifo_sel (pick_fifo),
    .index    (pick_idx)
  );

  // Next-state: decision captured only on the strobe.
  always_comb begin
    cap_en  = id_valid;
    valid_d = id_valid;
    acc_d   = acc_q;
    fifo_d  = fifo_q;
    idx_d   = idx_q;
    if (cap_en) begin
      acc_d  = pick_acc;
      fifo_d = pick_fifo;
      idx_d  = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      fifo_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      acc_q   <= acc_d;
      fifo_q  <= fifo_d;
      idx_q   <= idx_d;
    end
  end

  assign res_valid    = valid_q;
  assign res_accept   = acc_q;
  assign res_fifo_sel = fifo_q;
  assign res_index    = idx_q;
endmodule

// File: rtl/can_acc_checker.sv
module can_acc_checker #(
  parameter int unsigned NUM_FILT = 32,
  parameter int unsigned IDX_W    = $clog2(NUM_FILT)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           id_valid,
  input logic [31:0]                    cmp_word,
  input logic [NUM_FILT-1:0][31:0]      flt_mask,
  input logic [NUM_FILT-1:0][31:0]      flt_code,
  input logic [NUM_FILT-1:0]            flt_enable,
  input logic [IDX_W-1:0]               part_sel,
  input logic                           res_valid,
  input logic                           res_accept,
  input logic                           res_fifo_sel,
  input logic [IDX_W-1:0]               res_index
);
  logic [NUM_FILT-1:0] en_q;
  logic [IDX_W-1:0]    part_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      part_q <= '0;
    end else begin
      en_q   <= flt_enable;
      part_q <= part_sel;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_valid) else $error("strobe without result"); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !res_valid) else $error("result without strobe"); // R8
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (!res_fifo_sel && res_index == '0)) else $error("reject fields"); // R11
  AST_OFF_FIFO0: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && part_sel == '1) |=> !res_fifo_sel) else $error("FIFO-1 used while off"); // R6
  AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && flt_enable == '0) |=> !res_accept) else $error("accept with no filter"); // R3
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> (!res_accept || en_q[res_index])) else $error("winner disabled"); // R3
  AST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && part_sel != '1) |=> (!res_accept || (res_fifo_sel == (res_index > part_q)))) else $error("routing"); // R7
  AST_LOW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && flt_enable[0] && (((cmp_word ^ flt_code[0]) & flt_mask[0]) == '0))
      |=> (res_accept && res_index == '0)) else $error("filter 0 hit lost"); // R5
endmodule

bind can_acc_bank can_acc_checker #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .id_valid     (id_valid),
  .cmp_word     (cmp_word),
  .flt_mask     (flt_mask),
  .flt_code     (flt_code),
  .flt_enable   (flt_enable),
  .part_sel     (part_sel),
  .res_valid    (res_valid),
  .res_accept   (res_accept),
  .res_fifo_sel (res_fifo_sel),
  .res_index    (res_index)
);

// File: tb/can_acc_bank_test.sv
`timescale 1ns/1ps
module can_acc_bank_test;
  localparam int NF = 32;

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [28:0] ident;
    logic [4:0]  part;
    logic        acc;
    logic        fifo;
    logic [4:0]  idx;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 29'h123,       5'd31, 1'b1, 1'b0, 5'd2},  // R4 R6
    '{1'b0, 1'b1, 29'h123,       5'd31, 1'b1, 1'b0, 5'd2},  // R2 remote masked out
    '{1'b0, 1'b0, 29'h123,       5'd1,  1'b1, 1'b1, 5'd2},  // R7 above partition
    '{1'b0, 1'b0, 29'h123,       5'd2,  1'b1, 1'b0, 5'd2},  // R7 boundary
    '{1'b0, 1'b0, 29'h124,       5'd31, 1'b0, 1'b0, 5'd0},  // R4 R11 reject
    '{1'b0, 1'b0, 29'h3A5,       5'd10, 1'b1, 1'b1, 5'd20}, // R2 partial mask
    '{1'b0, 1'b0, 29'h3A5,       5'd20, 1'b1, 1'b0, 5'd20}, // R7 boundary
    '{1'b1, 1'b0, 29'h1554_1234, 5'd4,  1'b1, 1'b1, 5'd5},  // R1 ext base
    '{1'b1, 1'b0, 29'h1554_1234, 5'd31, 1'b1, 1'b0, 5'd5},  // R6
    '{1'b1, 1'b1, 29'h123_4567,  5'd8,  1'b1, 1'b1, 5'd9},  // R1 full ext
    '{1'b1, 1'b0, 29'h123_4567,  5'd8,  1'b0, 1'b0, 5'd0},  // R1 remote bit 0
    '{1'b1, 1'b0, 29'h048C_0000, 5'd0,  1'b1, 1'b1, 5'd2},  // R1 ext base into std mask
    '{1'b0, 1'b0, 29'h555,       5'd31, 1'b0, 1'b0, 5'd0}   // R1 format bit 19
  };

  logic                 clk;
  logic                 rst_n;
  logic                 id_valid;
  logic [28:0]          id_ident;
  logic                 id_ext;
  logic                 id_rtr;
  logic [NF-1:0][31:0]  flt_mask;
  logic [NF-1:0][31:0]  flt_code;
  logic [NF-1:0]        flt_enable;
  logic [4:0]           part_sel;
  logic                 res_valid;
  logic                 res_accept;
  logic                 res_fifo_sel;
  logic [4:0]           res_index;

  int checks = 0;
  int errors = 0;
  logic [NF-1:0] base_en;

  can_acc_bank #(.NUM_FILT(NF)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_valid     (id_valid),
    .id_ident     (id_ident),
    .id_ext       (id_ext),
    .id_rtr       (id_rtr),
    .flt_mask     (flt_mask),
    .flt_code     (flt_code),
    .flt_enable   (flt_enable),
    .part_sel     (part_sel),
    .res_valid    (res_valid),
    .res_accept   (res_accept),
    .res_fifo_sel (res_fifo_sel),
    .res_index    (res_index)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] wstd(input logic [10:0] id, input logic rtr);
    return {id, rtr, 20'h0};
  endfunction

  function automatic logic [31:0] wext(input logic [28:0] id, input logic rtr);
    return {id[28:18], 1'b1, 1'b1, id[17:0], rtr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_res(input string tag, input logic v, input logic a, input logic f, input logic [4:0] i);
    chk({tag, " valid"}, 32'(res_valid), 32'(v));
    chk({tag, " accept"}, 32'(res_accept), 32'(a));
    chk({tag, " fifo"}, 32'(res_fifo_sel), 32'(f));
    chk({tag, " index"}, 32'(res_index), 32'(i));
  endtask

  // Drive one strobe at a negedge; result sampled at the following negedge.
  task automatic send(input logic ext, input logic rtr, input logic [28:0] id, input logic [4:0] part);
    id_ext   = ext;
    id_rtr   = rtr;
    id_ident = id;
    part_sel = part;
    id_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    id_valid   = 1'b0;
    id_ident   = '0;
    id_ext     = 1'b0;
    id_rtr     = 1'b0;
    part_sel   = 5'd31;
    flt_mask   = '0;
    flt_code   = '0;
    flt_enable = '0;
    flt_mask[2]  = 32'hFFE0_0000; flt_code[2]  = wstd(11'h123, 1'b0);
    flt_mask[5]  = 32'hFFF8_0000; flt_code[5]  = {11'h555, 1'b1, 1'b1, 19'h0};
    flt_mask[9]  = 32'hFFFF_FFFF; flt_code[9]  = wext(29'h123_4567, 1'b1);
    flt_mask[12] = 32'h0;         flt_code[12] = 32'h0;
    flt_mask[20] = 32'hF000_0000; flt_code[20] = 32'h7000_0000;
    flt_mask[25] = 32'hFFE0_0000; flt_code[25] = wstd(11'h123, 1'b0);
    base_en = '0;
    base_en[2] = 1'b1; base_en[5] = 1'b1; base_en[9] = 1'b1;
    base_en[20] = 1'b1; base_en[25] = 1'b1;

    repeat (3) @(negedge clk);
    chk_res("R10 reset", 1'b0, 1'b0, 1'b0, 5'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_res("R10 after release", 1'b0, 1'b0, 1'b0, 5'd0);

    // R3: nothing enabled -> reject
    flt_enable = '0;
    send(1'b0, 1'b0, 29'h123, 5'd31);
    id_valid = 1'b0;
    chk_res("R3 none enabled", 1'b1, 1'b0, 1'b0, 5'd0);

    flt_enable = base_en;
    for (int n = 0; n < NV; n++) begin
      send(VECS[n].ext, VECS[n].rtr, VECS[n].ident, VECS[n].part);
      id_valid = 1'b0;
      chk_res($sformatf("R1/R2/R4/R6/R7 vec%0d", n), 1'b1, VECS[n].acc, VECS[n].fifo, VECS[n].idx);
      @(negedge clk);
      chk("R8 single pulse", 32'(res_valid), 32'd0);
    end

    // R5: filter 2 disabled -> overlap resolves to 25
    flt_enable[2] = 1'b0;
    send(1'b0, 1'b0, 29'h123, 5'd31);
    id_valid = 1'b0;
    chk_res("R5 next overlap", 1'b1, 1'b1, 1'b0, 5'd25);
    send(1'b0, 1'b0, 29'h123, 5'd24);
    id_valid = 1'b0;
    chk_res("R7 idx25 part24", 1'b1, 1'b1, 1'b1, 5'd25);

    // R3: match-all filter 12 enabled wins below 20/25
    flt_enable[12] = 1'b1;
    send(1'b0, 1'b0, 29'h3A5, 5'd12);
    id_valid = 1'b0;
    chk_res("R3 enable effect", 1'b1, 1'b1, 1'b0, 5'd12);
    flt_enable = base_en;

    // R9: filter state changed after the strobe edge does not alter the result
    send(1'b0, 1'b0, 29'h123, 5'd1);
    id_valid   = 1'b0;
    flt_enable = '0;
    flt_code[2] = 32'h0;
    part_sel   = 5'd31;
    chk_res("R9 late change", 1'b1, 1'b1, 1'b1, 5'd2);
    @(negedge clk);
    chk_res("R9 held", 1'b0, 1'b1, 1'b1, 5'd2);
    flt_code[2] = wstd(11'h123, 1'b0);
    flt_enable  = base_en;

    // R8: back-to-back strobes
    send(1'b0, 1'b0, 29'h123, 5'd31);
    chk_res("R8 first of pair", 1'b1, 1'b1, 1'b0, 5'd2);
    send(1'b0, 1'b0, 29'h124, 5'd31);
    id_valid = 1'b0;
    chk_res("R8 R11 second of pair", 1'b1, 1'b0, 1'b0, 5'd0);
    @(negedge clk);
    chk("R8 idle", 32'(res_valid), 32'd0);

    // R10: reset mid-run clears outputs
    send(1'b0, 1'b0, 29'h3A5, 5'd10);
    id_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk_res("R10 async clear", 1'b0, 1'b0, 1'b0, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule